// File: doc/BRIEF.md
# Byte-Stream Network Register Block

This block connects a processor register bus to a simple byte-wide network port. It holds one received frame and one outgoing frame in two internal byte buffers. Software reads a received frame one byte at a time through a data port, and a count register shows how many bytes are still unread. To send a frame, software programs a byte count and then writes that many bytes through a second data port. When the last byte arrives, the block takes the frame and sends it out on a valid/ready byte stream.

One interrupt line reports three events: a transmit has finished, a receive frame is waiting, and a test interrupt raised by software. After a frame arrives, further incoming frames are refused until software acknowledges the receive flag. The buffer depth is a parameter. Frame lengths are counted in a 17-bit field, which covers up to 65536 bytes.

The bus address is a byte offset inside a 64-byte window. Only bits [5:2] are decoded. A read returns its data on `bus_rdata` in the cycle after `bus_rd`, and the value stays there until the next read.

Top module: `bytenet_mmio`

## Requirements
- R1: Word offset 0x00 reads 0x45545942 and offset 0x04 reads 0x3154454E. Together they spell "BYTENET1", least-significant byte first. Read data appears the cycle after the read strobe and holds until the next read.
- R2: Offsets that are not mapped (0x18, 0x24 to 0x3c) read as 0.
- R3: Offset 0x08 bit 0 reads 1 in two cases: a receive frame has taken bytes but not yet its end byte, or a transmit frame has been taken but its last byte has not yet been accepted. Otherwise it reads 0.
- R4: When an accepted frame's end byte arrives, offset 0x0c is loaded with the frame length. Each read of offset 0x1c returns the next byte in bits [7:0], with upper bits 0, and lowers the count by one. Once the count is 0, reads of 0x1c return 0 and the count stays 0.
- R5: Offset 0x14 bit 1 is set when a frame ends. While it is set, a frame that starts is discarded whole, including bytes that arrive after the bit is cleared partway through that frame.
- R6: A frame longer than DEPTH bytes keeps its first DEPTH bytes, and its count reads DEPTH.
- R7: Writing offset 0x10 sets the transmit count to min(wdata[16:0], DEPTH) and restarts the byte tally. Writes to 0x20 store wdata[7:0]. When the tally equals a nonzero count, the frame is taken and 0x10 reads 0. The bytes then leave in order, with `tx_last` on the final byte, and each byte is held while `tx_ready` is low.
- R8: Offset 0x14 bit 0 is set when the last byte of a frame is accepted by the outgoing stream.
- R9: Writing 1 to bit 0 or bit 1 of 0x14 clears that flag. Writing 0 to either bit leaves it unchanged.
- R10: Any write to 0x14 sets bit 31 equal to wdata[31]. A read of 0x14 returns bit 31 as it was and then clears it.
- R11: `irq` is high exactly when any of bits 0, 1 or 31 of 0x14 is set.
- R12: While a frame is being sent, writes to 0x10 and 0x20 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte offset in the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| rx_valid | input | 1 | Incoming byte valid |
| rx_byte | input | 8 | Incoming byte |
| rx_last | input | 1 | Incoming byte ends the frame |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_byte | output | 8 | Outgoing byte |
| tx_last | output | 1 | Outgoing byte is the final one of the frame |
| tx_ready | input | 1 | Outgoing stream accepts the byte |
| irq | output | 1 | Interrupt request |

## Verification
Receive is driven with four frame patterns, each aimed at a different fault. A short frame read to exhaustion exposes count and order errors. A frame arriving while the flag is still set exposes a missing lock. A frame whose flag is cleared partway through exposes a design that resumes mid-frame instead of dropping the frame. A frame longer than the buffer exposes truncation and count-cap faults. Transmit is driven three ways. A free-flowing sink shows byte order and the last marker. A stalled and then toggling `tx_ready` shows that each byte is held until taken and that writes made while sending are ignored. A one-byte frame shows the edge case where the first byte is also the last. Every clock, a behavioural model is compared with the interrupt line, each outgoing handshake and each read.

// File: rtl/bytenet_pkg.sv
package bytenet_pkg;
  // frame lengths up to 65536 need 17 bits
  localparam int MAX_FRAME = 65536;
  localparam int CW        = $clog2(MAX_FRAME) + 1;

  // identification value, least-significant byte first: "BYTENET1"
  localparam logic [63:0] DEV_ID = "1TENETYB";

  // word index = byte offset [5:2]
  localparam logic [3:0] W_ID_LO  = 4'h0;
  localparam logic [3:0] W_ID_HI  = 4'h1;
  localparam logic [3:0] W_BUSY   = 4'h2;
  localparam logic [3:0] W_RXCNT  = 4'h3;
  localparam logic [3:0] W_TXCNT  = 4'h4;
  localparam logic [3:0] W_IRQ    = 4'h5;
  localparam logic [3:0] W_RXDATA = 4'h7;
  localparam logic [3:0] W_TXDATA = 4'h8;

  typedef enum logic [1:0] {TX_IDLE, TX_LOAD, TX_SEND} tx_state_e;
endpackage

// File: rtl/bytenet_rx.sv
module bytenet_rx
  import bytenet_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [7:0]    in_byte,
  input  logic          in_last,
  input  logic          locked,
  input  logic          rd_pop,
  output logic          frame_done,
  output logic          active,
  output logic [CW-1:0] count,
  output logic [7:0]    rd_byte
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] len;
  logic [PW-1:0] rptr;
  logic          dropping;
  logic          rd_ok;
  logic [7:0]    rd_q;
  logic          accept;

  assign accept     = in_valid && !dropping && (active || !locked);
  assign frame_done = accept && in_last;

  always_ff @(posedge clk) begin
    if (accept && len < DEPTH_C) mem[len[PW-1:0]] <= in_byte;
  end

  always_ff @(posedge clk) begin
    if (rd_pop) rd_q <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      dropping <= 1'b0;
      len      <= '0;
      count    <= '0;
      rptr     <= '0;
      rd_ok    <= 1'b0;
    end else begin
      if (in_valid && !active && !dropping && locked && !in_last) dropping <= 1'b1;
      if (in_valid && dropping && in_last) dropping <= 1'b0;
      if (rd_pop) rd_ok <= (count != '0);
      if (accept) begin
        if (in_last) begin
          active <= 1'b0;
          len    <= '0;
          count  <= (len < DEPTH_C) ? len + 1'b1 : DEPTH_C;
          rptr   <= '0;
        end else begin
          active <= 1'b1;
          if (len < DEPTH_C) len <= len + 1'b1;
        end
      end else if (rd_pop && count != '0) begin
        count <= count - 1'b1;
        rptr  <= rptr + 1'b1;
      end
    end
  end

  assign rd_byte = rd_ok ? rd_q : 8'h00;

  AST_RX_CNT_CAP: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> count <= DEPTH_C); // R6
  AST_RX_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (in_valid && locked && !active) |=> !active); // R5
  AST_RX_POP: assert property (@(posedge clk) disable iff (rst)
    (rd_pop && count != '0 && !frame_done) |=> count == $past(count) - 1'b1); // R4
endmodule

// File: rtl/bytenet_tx.sv
module bytenet_tx
  import bytenet_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cnt_we,
  input  logic [CW-1:0] cnt_wdata,
  input  logic          data_we,
  input  logic [7:0]    data_byte,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [7:0]    out_byte,
  output logic          out_last,
  output logic          sending,
  output logic [CW-1:0] prog_cnt,
  output logic          done
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  tx_state_e     state;
  logic [7:0]    mem [DEPTH];
  logic [CW-1:0] wcnt;
  logic [CW-1:0] len;
  logic [CW-1:0] ptr;
  logic [7:0]    q;
  logic          launch;
  logic          mem_rd;

  assign launch   = (state == TX_IDLE) && prog_cnt != '0 && wcnt == prog_cnt;
  assign out_valid = (state == TX_SEND);
  assign out_last  = (state == TX_SEND) && ptr == len;
  assign out_byte  = q;
  assign done      = out_valid && out_ready && out_last;
  assign sending   = (state != TX_IDLE);
  assign mem_rd    = (state == TX_LOAD) || (out_valid && out_ready && ptr != len);

  always_ff @(posedge clk) begin
    if (state == TX_IDLE && !launch && !cnt_we && data_we && wcnt < DEPTH_C)
      mem[wcnt[PW-1:0]] <= data_byte;
  end

  always_ff @(posedge clk) begin
    if (mem_rd) q <= mem[ptr[PW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= TX_IDLE;
      prog_cnt <= '0;
      wcnt     <= '0;
      len      <= '0;
      ptr      <= '0;
    end else begin
      case (state)
        TX_IDLE: begin
          if (launch) begin
            state    <= TX_LOAD;
            len      <= prog_cnt;
            prog_cnt <= '0;
            wcnt     <= '0;
            ptr      <= '0;
          end else if (cnt_we) begin
            prog_cnt <= (cnt_wdata > DEPTH_C) ? DEPTH_C : cnt_wdata;
            wcnt     <= '0;
          end else if (data_we && wcnt < DEPTH_C) begin
            wcnt <= wcnt + 1'b1;
          end
        end
        TX_LOAD: begin
          state <= TX_SEND;
          ptr   <= ptr + 1'b1;
        end
        TX_SEND: begin
          if (out_ready) begin
            if (ptr == len) state <= TX_IDLE;
            else ptr <= ptr + 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_last))); // R7
  AST_TX_TAKE: assert property (@(posedge clk) disable iff (rst)
    (state == TX_IDLE && prog_cnt != '0 && wcnt == prog_cnt) |=> (prog_cnt == '0 && sending)); // R7
  AST_TX_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (sending && cnt_we) |=> prog_cnt == '0); // R12
endmodule

// File: rtl/bytenet_irq.sv
module bytenet_irq (
  input  logic clk,
  input  logic rst,
  input  logic tx_done,
  input  logic rx_done,
  input  logic wr,
  input  logic clr_tx,
  input  logic clr_rx,
  input  logic test_val,
  input  logic rd,
  output logic tx_flag,
  output logic rx_flag,
  output logic test_flag,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      tx_flag   <= 1'b0;
      rx_flag   <= 1'b0;
      test_flag <= 1'b0;
    end else begin
      tx_flag <= tx_done || (tx_flag && !(wr && clr_tx));
      rx_flag <= rx_done || (rx_flag && !(wr && clr_rx));
      if (wr) test_flag <= test_val;
      else if (rd) test_flag <= 1'b0;
    end
  end

  assign irq = tx_flag | rx_flag | test_flag;

  AST_TX_SET: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> tx_flag); // R8
  AST_RX_SET: assert property (@(posedge clk) disable iff (rst)
    rx_done |=> rx_flag); // R5
  AST_W1C: assert property (@(posedge clk) disable iff (rst)
    (wr && clr_tx && !tx_done) |=> !tx_flag); // R9
  AST_TEST_RDCLR: assert property (@(posedge clk) disable iff (rst)
    (rd && !wr) |=> !test_flag); // R10
endmodule

// File: rtl/bytenet_mmio.sv
module bytenet_mmio
  import bytenet_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  bus_addr,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_last,
  output logic        tx_valid,
  output logic [7:0]  tx_byte,
  output logic        tx_last,
  input  logic        tx_ready,
  output logic        irq
);
  logic [3:0]    sel;
  logic          rx_done, rx_active, tx_done, tx_sending;
  logic [CW-1:0] rx_count, tx_prog;
  logic [7:0]    rx_rd_byte;
  logic          f_tx, f_rx, f_test;
  logic [31:0]   rd_mux, reg_q;
  logic          sel_rx_q;
  logic          unused_bits;

  assign sel         = bus_addr[5:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[30:17]};

  bytenet_rx #(.DEPTH(DEPTH)) u_rx (
    .clk(clk), .rst(rst),
    .in_valid(rx_valid), .in_byte(rx_byte), .in_last(rx_last),
    .locked(f_rx),
    .rd_pop(bus_rd && sel == W_RXDATA),
    .frame_done(rx_done), .active(rx_active),
    .count(rx_count), .rd_byte(rx_rd_byte)
  );

  bytenet_tx #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst(rst),
    .cnt_we(bus_wr && sel == W_TXCNT), .cnt_wdata(bus_wdata[CW-1:0]),
    .data_we(bus_wr && sel == W_TXDATA), .data_byte(bus_wdata[7:0]),
    .out_ready(tx_ready), .out_valid(tx_valid), .out_byte(tx_byte),
    .out_last(tx_last), .sending(tx_sending), .prog_cnt(tx_prog),
    .done(tx_done)
  );

  bytenet_irq u_irq (
    .clk(clk), .rst(rst),
    .tx_done(tx_done), .rx_done(rx_done),
    .wr(bus_wr && sel == W_IRQ),
    .clr_tx(bus_wdata[0]), .clr_rx(bus_wdata[1]), .test_val(bus_wdata[31]),
    .rd(bus_rd && sel == W_IRQ),
    .tx_flag(f_tx), .rx_flag(f_rx), .test_flag(f_test), .irq(irq)
  );

  always_comb begin
    case (sel)
      W_ID_LO: rd_mux = DEV_ID[31:0];
      W_ID_HI: rd_mux = DEV_ID[63:32];
      W_BUSY:  rd_mux = {31'b0, rx_active | tx_sending};
      W_RXCNT: rd_mux = 32'(rx_count);
      W_TXCNT: rd_mux = 32'(tx_prog);
      W_IRQ:   rd_mux = {f_test, 29'b0, f_rx, f_tx};
      default: rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_q    <= '0;
      sel_rx_q <= 1'b0;
    end else if (bus_rd) begin
      reg_q    <= rd_mux;
      sel_rx_q <= (sel == W_RXDATA);
    end
  end

  assign bus_rdata = sel_rx_q ? {24'b0, rx_rd_byte} : reg_q;

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R1
endmodule

// File: tb/bytenet_mmio_test.sv
`timescale 1ns/1ps
module bytenet_mmio_test;
  localparam int DEPTH = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        rx_valid = 1'b0, rx_last = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        tx_valid, tx_last, irq;
  logic [7:0]  tx_byte;
  logic        tx_ready = 1'b1;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  bytenet_mmio #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_last(rx_last), .tx_valid(tx_valid), .tx_byte(tx_byte),
    .tx_last(tx_last), .tx_ready(tx_ready), .irq(irq)
  );

  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [7:0] m_rbuf[$], m_rxq[$], m_tq[$], m_texp[$];
  int  m_rxcnt, m_tcnt, v;
  bit  m_ract, m_drop, m_sending, m_txf, m_rxf, m_test, ev_tx, ev_rx;
  logic [31:0] m_exp;

  always @(posedge clk) begin
    if (rst) begin
      m_rbuf.delete(); m_rxq.delete(); m_tq.delete(); m_texp.delete();
      m_rxcnt = 0; m_tcnt = 0; m_ract = 0; m_drop = 0; m_sending = 0;
      m_txf = 0; m_rxf = 0; m_test = 0; m_exp = 0;
    end else begin
      ev_tx = 0; ev_rx = 0;
      if (bus_rd) begin
        case (bus_addr[5:2])
          4'h0: m_exp = 32'h4554_5942;
          4'h1: m_exp = 32'h3154_454E;
          4'h2: m_exp = {31'b0, m_ract | m_sending};
          4'h3: m_exp = m_rxcnt;
          4'h4: m_exp = m_tcnt;
          4'h5: m_exp = {m_test, 29'b0, m_rxf, m_txf};
          4'h7: begin
            if (m_rxcnt > 0) begin m_exp = {24'b0, m_rxq.pop_front()}; m_rxcnt--; end
            else m_exp = 0;
          end
          default: m_exp = 0;
        endcase
      end
      if (rx_valid) begin
        if (m_drop) begin
          if (rx_last) m_drop = 0;
        end else if (m_ract || !m_rxf) begin
          if (m_rbuf.size() < DEPTH) m_rbuf.push_back(rx_byte);
          if (rx_last) begin
            m_rxq = m_rbuf; m_rxcnt = m_rbuf.size(); m_rbuf.delete();
            m_ract = 0; ev_rx = 1;
          end else m_ract = 1;
        end else if (!rx_last) m_drop = 1;
      end
      if (tx_valid && tx_ready) begin
        n_cmp++;
        if (m_texp.size() == 0) begin
          n_bad++; $display("FAIL R7: unexpected byte %02h, expected none", tx_byte);
        end else if (tx_byte !== m_texp[0] || tx_last !== (m_texp.size() == 1)) begin
          n_bad++;
          $display("FAIL R7: tx byte/last %02h/%0b expected %02h/%0b",
                   tx_byte, tx_last, m_texp[0], m_texp.size() == 1);
          void'(m_texp.pop_front());
        end else void'(m_texp.pop_front());
        if (tx_last) begin m_sending = 0; ev_tx = 1; end
      end else if (!m_sending && m_tcnt != 0 && m_tq.size() == m_tcnt) begin
        m_sending = 1; m_texp = m_tq; m_tq.delete(); m_tcnt = 0;
      end else if (!m_sending && bus_wr && bus_addr[5:2] == 4'h4) begin
        v = int'(bus_wdata[16:0]);
        m_tcnt = (v > DEPTH) ? DEPTH : v; m_tq.delete();
      end else if (!m_sending && bus_wr && bus_addr[5:2] == 4'h8) begin
        if (m_tq.size() < DEPTH) m_tq.push_back(bus_wdata[7:0]);
      end
      if (bus_wr && bus_addr[5:2] == 4'h5) begin
        if (bus_wdata[0]) m_txf = 0;
        if (bus_wdata[1]) m_rxf = 0;
        m_test = bus_wdata[31];
      end else if (bus_rd && bus_addr[5:2] == 4'h5) m_test = 0;
      if (ev_tx) m_txf = 1;
      if (ev_rx) m_rxf = 1;
    end
  end

  // R11: interrupt line compared on every clock
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (irq !== (m_txf | m_rxf | m_test)) begin
        n_bad++;
        $display("FAIL R11: irq %0b expected %0b", irq, m_txf | m_rxf | m_test);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0;
    n_cmp++;
    if (bus_rdata !== m_exp) begin
      n_bad++;
      $display("FAIL %s: read 0x%02h got %08h expected %08h", tag, a, bus_rdata, m_exp);
    end
  endtask

  task automatic rx_send(input int n, input logic [7:0] base, input bit with_end);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 1'b1; rx_byte = base + 8'(i);
      rx_last = with_end && (i == n - 1);
    end
    @(negedge clk); rx_valid = 1'b0; rx_last = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL R7: watchdog at cycle %0d, expected end before %0d", cyc, 100000);
      finish_run();
    end
  end

  initial begin
    idle(4); rst = 1'b0;
    // reset state, R1, R2, R3
    rd(6'h00, "R1"); rd(6'h04, "R1"); rd(6'h18, "R2"); rd(6'h24, "R2"); rd(6'h3c, "R2");
    rd(6'h08, "R3"); rd(6'h0c, "R4"); rd(6'h10, "R7"); rd(6'h14, "R10");
    // R4: short frame, busy mid-frame
    rx_send(3, 8'h10, 1'b0); rd(6'h08, "R3"); rx_send(2, 8'h20, 1'b1);
    rd(6'h0c, "R4"); rd(6'h08, "R3");
    for (int i = 0; i < 5; i++) rd(6'h1c, "R4");
    rd(6'h1c, "R4"); rd(6'h0c, "R4");
    // R5: locked receive drops frames
    rx_send(4, 8'h30, 1'b1); rd(6'h0c, "R5"); rd(6'h1c, "R5");
    rx_send(2, 8'h40, 1'b0); wr(6'h14, 32'h2); rx_send(2, 8'h50, 1'b1);
    rd(6'h0c, "R5"); rd(6'h14, "R9");
    rx_send(2, 8'h60, 1'b1); rd(6'h0c, "R5"); rd(6'h1c, "R5"); rd(6'h1c, "R5");
    // R9: writing 0 keeps flag, writing 1 clears
    wr(6'h14, 32'h0); rd(6'h14, "R9"); wr(6'h14, 32'h2); rd(6'h14, "R9");
    // R6: oversize frame
    rx_send(DEPTH + 5, 8'h80, 1'b1); rd(6'h0c, "R6");
    for (int i = 0; i <= DEPTH; i++) rd(6'h1c, "R6");
    wr(6'h14, 32'h2);
    // R7, R8: free-flowing transmit, upper data bits ignored
    wr(6'h10, 32'd4);
    for (int i = 0; i < 4; i++) wr(6'h20, 32'hFFFF_FF00 | (32'hA0 + 32'(i)));
    idle(12); rd(6'h14, "R8"); wr(6'h14, 32'h1); rd(6'h14, "R9"); rd(6'h10, "R7");
    // R7, R12: stalled sink, writes while sending ignored
    tx_ready = 1'b0;
    wr(6'h10, 32'd3);
    for (int i = 0; i < 3; i++) wr(6'h20, 32'hC0 + 32'(i));
    idle(4); rd(6'h10, "R7"); rd(6'h08, "R3");
    wr(6'h10, 32'd9); wr(6'h20, 32'h77); rd(6'h10, "R12");
    for (int i = 0; i < 8; i++) begin @(negedge clk); tx_ready = i[0]; end
    tx_ready = 1'b1; idle(6); rd(6'h08, "R3"); wr(6'h14, 32'h1);
    // R7: one-byte frame, stale byte must not appear
    wr(6'h10, 32'd1); wr(6'h20, 32'h5A); idle(8); rd(6'h14, "R8"); wr(6'h14, 32'h1);
    // R7: count clamp
    wr(6'h10, 32'd100); rd(6'h10, "R7"); wr(6'h10, 32'd0); rd(6'h10, "R7");
    // R10: test interrupt
    wr(6'h14, 32'h8000_0000); idle(1); rd(6'h14, "R10"); rd(6'h14, "R10");
    wr(6'h14, 32'h8000_0000); wr(6'h14, 32'h0); rd(6'h14, "R10");
    idle(5);
    n_cmp++;
    if (m_texp.size() != 0) begin
      n_bad++; $display("FAIL R7: %0d bytes never sent, expected 0", m_texp.size());
    end
    finish_run();
  end
endmodule